// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers fifteen interrupt request lines for a small 8-bit processor core. Every line latches into a pending flag. At each machine-cycle strobe the flags are snapshotted through per-source enables and one global enable, and the snapshot is arbitrated. Each source carries a 2-bit priority, where 3 is the most urgent. The winning request goes to the core as a request line, a 16-bit vector address and the winner's level.

The core accepts with a one-cycle acknowledge pulse. The controller then marks the winner's level as in service in a 4-bit mask. From that point only a request of strictly higher level can raise the request line again, which allows up to four nested handlers. A return pulse from the core retires the most urgent level still in service. The flags of the four lowest-numbered sources (two external pins and two timers) clear themselves when acknowledged. Software clears all other flags with a clear mask.

Source slots 0–5, 6–11 and 12–14 map to interrupt numbers 0–5, 8–13 and 16–18. Each vector lies eight bytes above the previous number's vector and starts at offset 3.

Top module: `irq_nest_ctrl`

## Requirements
- R1: A high bit on `src_i` sets the matching bit of `flag_o` on the next clock edge, whatever the enables say. In the same cycle a set beats a clear.
- R2: A high bit on `flag_clr_i` clears the matching flag on the next edge, unless that source is set in the same cycle.
- R3: Requests come only from the snapshot taken at an edge where `mc_tick_i` is high. A flag set after the last snapshot raises nothing until the next one.
- R4: A source enters the snapshot only if its `en_i` bit and `gie_i` are both high at the snapshot edge.
- R5: Among eligible snapshot entries, the highest priority wins (field `prio_i[2i+1:2i]` for slot i, 3 most urgent). Equal priorities resolve to the lowest slot. `lvl_o` shows the winner's level, and shows 0 when there is no request.
- R6: `vec_o` = 8·n+3, where n = i for slots 0–5, i+2 for slots 6–11 and i+4 for slots 12–14 (e.g. 0x0003, 0x0013, 0x0093). It is 0 when `req_o` is low.
- R7: An entry is eligible only if its priority is strictly above every level set in `isr_o`. `req_o` is high exactly when some entry is eligible.
- R8: `ack_i` with `req_o` high sets `isr_o[lvl_o]` on the next edge. `ack_i` with `req_o` low changes nothing.
- R9: `reti_i` clears the highest set bit of `isr_o`. With an empty mask it has no effect.
- R10: An accepted acknowledge clears the winner's flag only for slots 0–3. Other flags stay set.
- R11: During reset the flags, the snapshot and the in-service mask are all zero, so `req_o`, `vec_o`, `lvl_o`, `isr_o` and `flag_o` read 0.
- R12: An accepted entry leaves the snapshot, so it cannot request again before the next `mc_tick_i` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mc_tick_i | input | 1 | Machine-cycle strobe that takes the snapshot |
| src_i | input | 15 | Request condition per slot |
| flag_clr_i | input | 15 | Software clear mask for flags |
| en_i | input | 15 | Per-slot enable |
| gie_i | input | 1 | Global enable |
| prio_i | input | 30 | 2-bit priority per slot |
| ack_i | input | 1 | Core accepts current request |
| reti_i | input | 1 | Core returns from a handler |
| req_o | output | 1 | Request to core |
| vec_o | output | 16 | Vector address of the winner |
| lvl_o | output | 2 | Level of the winner |
| isr_o | output | 4 | In-service mask, one bit per level |
| flag_o | output | 15 | Pending flags |

## Verification
A wrong bit in the in-service mask appears on `isr_o` on the very next edge. It also changes `req_o` in the same cycle whenever a snapshot entry sits at or below the corrupted level, so both preemption and its absence are visible at once. A stale or missing snapshot entry appears as a wrong `req_o` or `vec_o` in the cycle after the strobe edge. A flag error can be read straight from `flag_o` one edge after the stimulus. The bench compares every output in every cycle against a cycle model, so any divergence is reported within one cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned GRP_SIZE = 6;
  localparam int unsigned GRP_GAP  = 2;
  localparam int unsigned VEC_STEP = 8;
  localparam int unsigned VEC_OFS  = 3;

  // slot index -> interrupt number (groups of six, gaps of two)
  function automatic int unsigned slot_num(input int unsigned idx);
    return idx + GRP_GAP * (idx / GRP_SIZE);
  endfunction

  function automatic int unsigned slot_vec(input int unsigned idx);
    return VEC_STEP * slot_num(idx) + VEC_OFS;
  endfunction
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int NSRC = 15
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] src_i,
  input  logic [NSRC-1:0] clr_i,
  input  logic [NSRC-1:0] auto_clr_i,
  input  logic            tick_i,
  input  logic [NSRC-1:0] en_i,
  input  logic            gie_i,
  input  logic [NSRC-1:0] take_i,
  output logic [NSRC-1:0] flag_o,
  output logic [NSRC-1:0] samp_o
);
  logic [NSRC-1:0] flag_q, samp_q, flag_d, samp_d;

  always_comb begin
    flag_d = (flag_q & ~clr_i & ~auto_clr_i) | src_i;
    samp_d = (tick_i ? (flag_q & en_i & {NSRC{gie_i}}) : samp_q) & ~take_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= '0;
      samp_q <= '0;
    end else begin
      flag_q <= flag_d;
      samp_q <= samp_d;
    end
  end

  assign flag_o = flag_q;
  assign samp_o = samp_q;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NSRC  = 15,
  parameter int NLVL  = 4,
  parameter int PW    = $clog2(NLVL),
  parameter int IDX_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]    samp_i,
  input  logic [NSRC*PW-1:0] prio_i,
  input  logic [NLVL-1:0]    isr_i,
  output logic               req_o,
  output logic [IDX_W-1:0]   win_o,
  output logic [PW-1:0]      lvl_o
);
  logic [NSRC-1:0] elig;

  // eligible when no in-service bit sits at or above the slot's level
  for (genvar g = 0; g < NSRC; g++) begin : g_elig
    assign elig[g] = samp_i[g] && ((isr_i >> prio_i[g*PW +: PW]) == '0);
  end

  // descending scan with >= keeps the lowest slot among equal levels
  always_comb begin
    req_o = 1'b0;
    win_o = '0;
    lvl_o = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (elig[i] && (!req_o || prio_i[i*PW +: PW] >= lvl_o)) begin
        req_o = 1'b1;
        win_o = IDX_W'(i);
        lvl_o = prio_i[i*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/irq_vec_gen.sv
module irq_vec_gen
  import irq_pkg::*;
#(
  parameter int NSRC   = 15,
  parameter int ADDR_W = 16,
  parameter int IDX_W  = $clog2(NSRC)
) (
  input  logic              req_i,
  input  logic [IDX_W-1:0]  win_i,
  output logic [ADDR_W-1:0] vec_o
);
  logic [ADDR_W-1:0] tab [NSRC];

  for (genvar g = 0; g < NSRC; g++) begin : g_tab
    assign tab[g] = ADDR_W'(slot_vec(g));
  end

  assign vec_o = req_i ? tab[win_i] : '0;
endmodule

// File: rtl/irq_isr_stack.sv
module irq_isr_stack #(
  parameter int NLVL = 4,
  parameter int PW   = $clog2(NLVL)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_i,
  input  logic [PW-1:0]   push_lvl_i,
  input  logic            pop_i,
  output logic [NLVL-1:0] isr_o
);
  logic [NLVL-1:0] isr_q, popped, isr_d;
  logic            found;

  always_comb begin
    popped = isr_q;
    found  = 1'b0;
    if (pop_i) begin
      for (int l = NLVL - 1; l >= 0; l--) begin
        if (!found && isr_q[l]) begin
          popped[l] = 1'b0;
          found     = 1'b1;
        end
      end
    end
    isr_d = popped | (push_i ? (NLVL'(1) << push_lvl_i) : '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) isr_q <= '0;
    else         isr_q <= isr_d;
  end

  assign isr_o = isr_q;
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl #(
  parameter int              NSRC      = 15,
  parameter int              NLVL      = 4,
  parameter int              ADDR_W    = 16,
  parameter logic [NSRC-1:0] AUTO_MASK = NSRC'(4'hF)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          mc_tick_i,
  input  logic [NSRC-1:0]               src_i,
  input  logic [NSRC-1:0]               flag_clr_i,
  input  logic [NSRC-1:0]               en_i,
  input  logic                          gie_i,
  input  logic [NSRC*$clog2(NLVL)-1:0]  prio_i,
  input  logic                          ack_i,
  input  logic                          reti_i,
  output logic                          req_o,
  output logic [ADDR_W-1:0]             vec_o,
  output logic [$clog2(NLVL)-1:0]       lvl_o,
  output logic [NLVL-1:0]               isr_o,
  output logic [NSRC-1:0]               flag_o
);
  localparam int PW    = $clog2(NLVL);
  localparam int IDX_W = $clog2(NSRC);

  logic [NSRC-1:0]  samp, take;
  logic [IDX_W-1:0] win;
  logic [PW-1:0]    lvl;
  logic             req, acc;

  assign acc  = ack_i && req;
  assign take = acc ? (NSRC'(1) << win) : '0;

  irq_flag_bank #(.NSRC(NSRC)) u_flags (
    .clk_i, .rst_ni,
    .src_i,
    .clr_i      (flag_clr_i),
    .auto_clr_i (take & AUTO_MASK),
    .tick_i     (mc_tick_i),
    .en_i, .gie_i,
    .take_i     (take),
    .flag_o,
    .samp_o     (samp)
  );

  irq_arbiter #(.NSRC(NSRC), .NLVL(NLVL), .PW(PW), .IDX_W(IDX_W)) u_arb (
    .samp_i (samp),
    .prio_i,
    .isr_i  (isr_o),
    .req_o  (req),
    .win_o  (win),
    .lvl_o  (lvl)
  );

  irq_vec_gen #(.NSRC(NSRC), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_vec (
    .req_i (req),
    .win_i (win),
    .vec_o
  );

  irq_isr_stack #(.NLVL(NLVL), .PW(PW)) u_isr (
    .clk_i, .rst_ni,
    .push_i     (acc),
    .push_lvl_i (lvl),
    .pop_i      (reti_i),
    .isr_o
  );

  assign req_o = req;
  assign lvl_o = lvl;
endmodule

// File: rtl/irq_nest_ctrl_chk.sv
module irq_nest_ctrl_chk #(
  parameter int NSRC   = 15,
  parameter int NLVL   = 4,
  parameter int ADDR_W = 16
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [NSRC-1:0]         src_i,
  input logic                    ack_i,
  input logic                    reti_i,
  input logic                    req_o,
  input logic [ADDR_W-1:0]       vec_o,
  input logic [$clog2(NLVL)-1:0] lvl_o,
  input logic [NLVL-1:0]         isr_o,
  input logic [NSRC-1:0]         flag_o
);
  // R1
  src_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i != '0) |=> ((flag_o & $past(src_i)) == $past(src_i)));

  // R7
  req_above_isr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> ((isr_o >> lvl_o) == '0));

  // R6
  vec_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (vec_o[2:0] == 3'd3 && vec_o <= ADDR_W'(16'h0093)));

  // R8
  ack_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && req_o && !reti_i) |=> ($countones(isr_o) == $countones($past(isr_o)) + 1));

  // R8
  ack_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !req_o && !reti_i) |=> $stable(isr_o));

  // R9
  reti_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && !ack_i && isr_o != '0) |=> ($countones(isr_o) == $countones($past(isr_o)) - 1));

  // R9
  reti_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && !ack_i && isr_o == '0) |=> (isr_o == '0));
endmodule

bind irq_nest_ctrl irq_nest_ctrl_chk #(.NSRC(NSRC), .NLVL(NLVL), .ADDR_W(ADDR_W)) u_chk (
  .clk_i, .rst_ni, .src_i, .ack_i, .reti_i,
  .req_o, .vec_o, .lvl_o, .isr_o, .flag_o
);

// File: tb/irq_nest_ctrl_test.sv
`timescale 1ns/1ps
module irq_nest_ctrl_test;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        mc_tick_i = 0, gie_i = 0, ack_i = 0, reti_i = 0;
  logic [14:0] src_i = '0, flag_clr_i = '0, en_i = '0, flag_o;
  logic [29:0] prio_i = '0;
  logic        req_o;
  logic [15:0] vec_o;
  logic [1:0]  lvl_o;
  logic [3:0]  isr_o;

  irq_nest_ctrl uut (.*);

  always #10 clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [14:0] m_flag = '0, m_samp = '0;
  logic [3:0]  m_isr = '0;
  logic        e_req;
  logic [3:0]  e_win;
  logic [1:0]  e_lvl;
  logic [15:0] e_vec;

  function automatic int unsigned num_of(input int i);
    if (i < 6) return i;
    else if (i < 12) return i + 2;
    return i + 4;
  endfunction

  task automatic predict();
    e_req = 0; e_win = 0; e_lvl = 0; e_vec = 0;
    for (int i = 0; i < 15; i++) begin
      logic [1:0] p;
      p = prio_i[2*i +: 2];
      if (m_samp[i] && (m_isr >> p) == 0 && (!e_req || p > e_lvl)) begin
        e_req = 1; e_win = 4'(i); e_lvl = p;
      end
    end
    if (e_req) e_vec = 16'(8 * num_of(int'(e_win)) + 3);
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [14:0] src, input logic [14:0] clr,
                      input logic tick, input logic ack, input logic reti);
    logic [14:0] take, nf, ns;
    logic [3:0]  ni;
    bit          hit;
    @(negedge clk_i);
    src_i = src; flag_clr_i = clr; mc_tick_i = tick; ack_i = ack; reti_i = reti;
    #1;
    predict();
    chk(req_o, e_req, "R7 req");
    chk(lvl_o, e_lvl, "R5 lvl");
    chk(vec_o, e_vec, "R6 vec");
    chk(isr_o, m_isr, "R8 isr");
    chk(flag_o, m_flag, "R1 flag");
    take = (ack && e_req) ? (15'(1) << e_win) : '0;
    nf = (m_flag & ~clr & ~(take & 15'h000F)) | src;
    ns = (tick ? (m_flag & en_i & {15{gie_i}}) : m_samp) & ~take;
    ni = m_isr; hit = 0;
    if (reti) for (int l = 3; l >= 0; l--) if (!hit && ni[l]) begin ni[l] = 0; hit = 1; end
    if (ack && e_req) ni[e_lvl] = 1'b1;
    @(posedge clk_i);
    #1;
    m_flag = nf; m_samp = ns; m_isr = ni;
    src_i = '0; flag_clr_i = '0; mc_tick_i = 0; ack_i = 0; reti_i = 0;
  endtask

  initial begin
    #(20ns * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2741));
    repeat (3) @(negedge clk_i);
    #1;
    // R11 reset state
    chk(req_o, 0, "R11 req"); chk(vec_o, 0, "R11 vec"); chk(lvl_o, 0, "R11 lvl");
    chk(isr_o, 0, "R11 isr"); chk(flag_o, 0, "R11 flag");
    en_i = '1; gie_i = 1; prio_i = '0;
    @(negedge clk_i); rst_ni = 1;
    @(posedge clk_i); #1;

    step(15'(1) << 14, 0, 0, 0, 0);
    chk(flag_o[14], 1, "R1 flag set"); chk(req_o, 0, "R3 no request before snapshot");
    step(0, 0, 1, 0, 0);
    chk(req_o, 1, "R3 request after snapshot"); chk(vec_o, 16'h0093, "R6 slot 14");
    step(15'(1) << 2, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0);
    chk(vec_o, 16'h0013, "R5 tie lowest slot");
    prio_i[29:28] = 2'd3; #1;
    chk(vec_o, 16'h0093, "R5 higher level wins"); chk(lvl_o, 3, "R5 lvl");
    step(0, 0, 0, 1, 0);
    chk(isr_o, 4'b1000, "R8 push"); chk(flag_o[14], 1, "R10 no auto clear");
    chk(req_o, 0, "R7 equal/lower blocked");
    step(0, 0, 0, 0, 1);
    chk(isr_o, 0, "R9 pop"); chk(vec_o, 16'h0013, "R7 resumes lower");
    step(0, 0, 0, 1, 0);
    chk(flag_o[2], 0, "R10 auto clear"); chk(req_o, 0, "R12 taken entry gone");
    step(0, 0, 0, 0, 1);
    chk(req_o, 0, "R12 no rerequest");
    step(0, 15'(1) << 14, 0, 0, 0);
    chk(flag_o, 0, "R2 clear");
    step(15'h4000, 15'h4000, 0, 0, 0);
    chk(flag_o[14], 1, "R2 set beats clear");
    step(0, 15'h4000, 0, 0, 0);
    en_i[0] = 0;
    step(15'd1, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0);
    chk(req_o, 0, "R4 slot disabled"); chk(flag_o[0], 1, "R1 flag while disabled");
    en_i = '1; gie_i = 0;
    step(0, 0, 1, 0, 0);
    chk(req_o, 0, "R4 global off");
    gie_i = 1;
    step(0, 0, 1, 0, 0);
    chk(req_o, 1, "R4 enabled"); chk(vec_o, 16'h0003, "R6 slot 0");
    prio_i[1:0] = 2'd1;
    step(0, 0, 0, 1, 0);
    chk(isr_o, 4'b0010, "R8 push lvl1");
    prio_i[9:8] = 2'd2;
    step(15'(1) << 4, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0);
    chk(req_o, 1, "R7 preempt"); chk(vec_o, 16'h0023, "R6 slot 4");
    step(0, 0, 0, 1, 0);
    chk(isr_o, 4'b0110, "R8 nested");
    step(15'(1) << 5, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0);
    chk(req_o, 0, "R7 no preempt");
    step(0, 0, 0, 0, 1);
    chk(isr_o, 4'b0010, "R9 highest first");
    step(0, 0, 0, 0, 1);
    step(0, '1, 0, 0, 0);
    step(0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 1);
    chk(isr_o, 0, "R9 empty pop");
    step(0, 0, 0, 1, 0);
    chk(isr_o, 0, "R8 ack without request");

    for (int c = 0; c < 5000; c++) begin
      logic [14:0] s, k;
      if ($urandom % 40 == 0) prio_i = 30'($urandom);
      if ($urandom % 60 == 0) en_i = 15'($urandom | $urandom);
      gie_i = ($urandom % 10) != 0;
      s = ($urandom % 3 == 0) ? 15'($urandom & $urandom & $urandom) : '0;
      k = ($urandom % 6 == 0) ? 15'($urandom & $urandom) : '0;
      step(s, k, ($urandom % 3) == 0, ($urandom % 3) == 0, ($urandom % 7) == 0);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule